// File: doc/BRIEF.md
# Serial ID ROM Reader

This block reads the 64-bit factory code from a single serial-number device on a one-wire bus and turns it into a 64-bit extended unique identifier. It does not drive the wire. It sequences a separate one-wire master through a byte-level request/acknowledge handshake. Three operations are used: a bus reset with presence sampling, a byte write, and a byte read.

A one-cycle start pulse begins one attempt. The reader resets the bus. If a device answers, it sends the read-ROM command and then reads the family byte, six serial bytes and a check byte. While the bytes arrive, a reflected CRC-8 is folded over the family and serial bytes. At the end, the family code and the check byte are both tested.

On success, the serial bytes are placed in reverse arrival order into the upper identifier bytes. The lowest three bytes are overwritten with a fixed 24-bit prefix. On any failure the identifier is cleared. Either way a one-cycle done pulse carries exactly one of the ok or fail flags.

Top module: `serial_id_reader`

## Requirements
- R1: After a start pulse in idle, the reader requests operations in this order: one bus reset (op 0), one write (op 1) of data 0x33, then eight reads (op 2). Each request keeps `ow_req_o` high with `ow_op_o` and `ow_wdata_o` unchanged until the cycle in which `ow_ack_i` is high.
- R2: If `ow_present_i` is 0 when the reset request is acknowledged, the reader issues no write and no read, and finishes with fail.
- R3: The first byte read is the family code. Any value other than 0x01 gives fail.
- R4: Identifier byte k is `id_o[8k+7:8k]`. On success, reads 2 to 6 land in identifier bytes 7 down to 3 in arrival order. Read 7 lands in byte 2 and is then replaced by the prefix.
- R5: The check byte (read 8) must equal a CRC-8 computed over the family byte and then the six serial bytes in arrival order. The CRC starts at 0x00 and, per bit, XORs in the data LSB first, then shifts right and XORs 0x8C when the bit shifted out is 1. Any mismatch gives fail.
- R6: On success `ok_o` is high and identifier bytes 0, 1, 2 hold 0x00, 0x1A, 0x4C.
- R7: On fail, all 64 bits of `id_o` are zero.
- R8: `done_o` is high for exactly one cycle per attempt, with exactly one of `ok_o` and `fail_o` high in that cycle. `ok_o` and `fail_o` are low whenever `done_o` is low.
- R9: `id_o` changes only in a cycle in which `done_o` is high.
- R10: A start pulse while an attempt is in progress has no effect: no extra reset request and no extra done pulse.
- R11: After reset, `ow_req_o`, `done_o`, `ok_o` and `fail_o` are low and `id_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for one read attempt |
| ow_req_o | output | 1 | Operation request to the one-wire master |
| ow_op_o | output | 2 | Operation: 0 bus reset, 1 write byte, 2 read byte |
| ow_wdata_o | output | 8 | Byte to write |
| ow_ack_i | input | 1 | One-cycle completion of the current operation |
| ow_rdata_i | input | 8 | Byte read, valid with the acknowledge of a read |
| ow_present_i | input | 1 | Presence seen, valid with the acknowledge of a reset |
| done_o | output | 1 | Attempt finished (one cycle) |
| ok_o | output | 1 | Identifier valid |
| fail_o | output | 1 | Attempt failed |
| id_o | output | 64 | Assembled identifier, byte k at bits 8k+7:8k |

## Verification
The bench builds the reader with its default parameters: six serial bytes, family code 0x01, command 0x33 and prefix 0x001A4C. These defaults give the full 64-bit identifier with the 0x4C prefix byte overwriting the last serial byte.

A behavioural one-wire master acknowledges after a random delay and serves bytes from a bench-side ROM image. The bench runs random serial numbers with correct checksums, single corrupted check bytes, wrong family codes, absent devices, and start pulses injected mid-attempt. Together these reach every exit path of the sequencer.

// File: rtl/sidr_pkg.sv
package sidr_pkg;
    typedef enum logic [1:0] {
        OP_BUS_RESET = 2'd0,
        OP_WRITE     = 2'd1,
        OP_READ      = 2'd2
    } ow_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESET,
        ST_CMD,
        ST_READ
    } rd_state_e;
endpackage

// File: rtl/sidr_crc8_step.sv
module sidr_crc8_step #(
    parameter logic [7:0] POLY = 8'h8C
) (
    input  logic [7:0] crc_i,
    input  logic [7:0] data_i,
    output logic [7:0] crc_o
);
    logic [8:0][7:0] stage;

    assign stage[0] = crc_i ^ data_i;

    for (genvar b = 0; b < 8; b++) begin : g_bit
        assign stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ POLY)
                                        : (stage[b] >> 1);
    end

    assign crc_o = stage[8];
endmodule

// File: rtl/serial_id_reader.sv
module serial_id_reader #(
    parameter int          SER_BYTES = 6,
    parameter logic [7:0]  FAMILY    = 8'h01,
    parameter logic [7:0]  READ_CMD  = 8'h33,
    parameter logic [23:0] PREFIX    = 24'h001A4C
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    output logic                          ow_req_o,
    output logic [1:0]                    ow_op_o,
    output logic [7:0]                    ow_wdata_o,
    input  logic                          ow_ack_i,
    input  logic [7:0]                    ow_rdata_i,
    input  logic                          ow_present_i,
    output logic                          done_o,
    output logic                          ok_o,
    output logic                          fail_o,
    output logic [8*(SER_BYTES+2)-1:0]    id_o
);
    import sidr_pkg::*;

    localparam int ID_BYTES  = SER_BYTES + 2;
    localparam int ID_W      = 8 * ID_BYTES;
    localparam int PFX_BYTES = 3;
    localparam int IDX_W     = $clog2(ID_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_BYTES - 1);

    typedef struct packed {
        rd_state_e        st;
        logic [IDX_W-1:0] idx;
        logic [7:0]       crc;
        logic [7:0]       fam;
        logic [ID_W-1:0]  stage;
        logic [ID_W-1:0]  id;
        logic             done;
        logic             ok;
        logic             fail;
    } regs_t;

    regs_t q, d;
    logic [7:0] crc_next;
    logic       good;
    logic [ID_W-1:0] id_good;

    sidr_crc8_step #(.POLY(8'h8C)) u_crc (
        .crc_i  (q.crc),
        .data_i (ow_rdata_i),
        .crc_o  (crc_next)
    );

    always_comb begin
        good    = (q.fam == FAMILY) && (q.crc == ow_rdata_i);
        id_good = q.stage;
        for (int j = 0; j < PFX_BYTES; j++) begin
            id_good[8*j +: 8] = PREFIX[8*(PFX_BYTES-1-j) +: 8];
        end
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.ok   = 1'b0;
        d.fail = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) d.st = ST_RESET;
            end
            ST_RESET: begin
                if (ow_ack_i) begin
                    if (ow_present_i) begin
                        d.st = ST_CMD;
                    end else begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.fail = 1'b1;
                        d.id   = '0;
                    end
                end
            end
            ST_CMD: begin
                if (ow_ack_i) begin
                    d.st  = ST_READ;
                    d.idx = '0;
                    d.crc = 8'h00;
                end
            end
            ST_READ: begin
                if (ow_ack_i) begin
                    if (q.idx == LAST_IDX) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.ok   = good;
                        d.fail = !good;
                        d.id   = good ? id_good : '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.crc = crc_next;
                        if (q.idx == '0) begin
                            d.fam = ow_rdata_i;
                        end
                        for (int k = 1; k < ID_BYTES - 1; k++) begin
                            if (q.idx == IDX_W'(k))
                                d.stage[8*(ID_BYTES-k) +: 8] = ow_rdata_i;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.idx   <= '0;
            q.crc   <= '0;
            q.fam   <= '0;
            q.stage <= '0;
            q.id    <= '0;
            q.done  <= 1'b0;
            q.ok    <= 1'b0;
            q.fail  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        ow_req_o   = (q.st != ST_IDLE);
        ow_op_o    = (q.st == ST_RESET) ? OP_BUS_RESET :
                     (q.st == ST_CMD)   ? OP_WRITE : OP_READ;
        ow_wdata_o = READ_CMD;
        done_o     = q.done;
        ok_o       = q.ok;
        fail_o     = q.fail;
        id_o       = q.id;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ow_req_o && !ow_ack_i |=> ow_req_o && $stable(ow_op_o)) else $error("req hold"); // R1
    AST_ABSENT_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        ow_req_o && ow_op_o == OP_BUS_RESET && ow_ack_i && !ow_present_i |=> done_o && fail_o && !ow_req_o) else $error("absent"); // R2
    AST_OK_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && ok_o |-> id_o[23:0] == {PREFIX[7:0], PREFIX[15:8], PREFIX[23:16]}) else $error("prefix"); // R6
    AST_FAIL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && fail_o |-> id_o == '0) else $error("fail id"); // R7
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $countones({ok_o, fail_o}) == 1) else $error("result"); // R8
    AST_RESULT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> !ok_o && !fail_o) else $error("stray flag"); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("long done"); // R8
    AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(id_o)) else $error("id moved"); // R9
endmodule

// File: tb/sim_serial_id_reader.sv
module sim_serial_id_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        ow_req_o;
    logic [1:0]  ow_op_o;
    logic [7:0]  ow_wdata_o;
    logic        ow_ack_i = 1'b0;
    logic [7:0]  ow_rdata_i = 8'h00;
    logic        ow_present_i = 1'b0;
    logic        done_o, ok_o, fail_o;
    logic [63:0] id_o;

    always #10 clk = ~clk;

    serial_id_reader u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .ow_req_o(ow_req_o), .ow_op_o(ow_op_o), .ow_wdata_o(ow_wdata_o),
        .ow_ack_i(ow_ack_i), .ow_rdata_i(ow_rdata_i), .ow_present_i(ow_present_i),
        .done_o(done_o), .ok_o(ok_o), .fail_o(fail_o), .id_o(id_o)
    );

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;

    logic [7:0] rom [8];
    logic       dev_present;
    int         n_ops, n_resets, seq_err;

    task automatic chk(input logic cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_add(input logic [7:0] acc, input logic [7:0] b);
        logic [7:0] a;
        a = acc ^ b;
        for (int i = 0; i < 8; i++) a = a[0] ? ((a >> 1) ^ 8'h8C) : (a >> 1);
        return a;
    endfunction

    function automatic logic [7:0] rom_crc();
        logic [7:0] a;
        a = 8'h00;
        for (int i = 0; i < 7; i++) a = crc_add(a, rom[i]);
        return a;
    endfunction

    function automatic logic [63:0] exp_good_id();
        return {rom[1], rom[2], rom[3], rom[4], rom[5], 8'h4C, 8'h1A, 8'h00};
    endfunction

    // behavioural one-wire master with a ROM image
    initial begin
        int rd_idx;
        rd_idx = 0;
        forever begin
            @(negedge clk);
            if (rst_n && ow_req_o && !ow_ack_i) begin
                repeat ($urandom % 4) @(negedge clk);
                if (n_ops == 0 && ow_op_o != 2'd0) seq_err++;
                if (n_ops == 1 && (ow_op_o != 2'd1 || ow_wdata_o != 8'h33)) seq_err++;
                if (n_ops >= 2 && ow_op_o != 2'd2) seq_err++;
                if (n_ops > 9) seq_err++;
                if (ow_op_o == 2'd0) begin
                    n_resets++;
                    rd_idx = 0;
                    ow_present_i = dev_present;
                end else if (ow_op_o == 2'd2) begin
                    ow_rdata_i = rom[rd_idx % 8];
                    rd_idx++;
                end
                n_ops++;
                ow_ack_i = 1'b1;
                @(negedge clk);
                ow_ack_i = 1'b0;
            end
        end
    end

    task automatic run(input logic present, input logic exp_ok, input logic busy_start, input string tag);
        logic [63:0] prev_id, want;
        int          waited, moved, extra_done;
        prev_id = id_o;
        want = exp_ok ? exp_good_id() : 64'h0;
        dev_present = present;
        n_ops = 0; n_resets = 0; seq_err = 0; moved = 0; extra_done = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        waited = 0;
        while (!done_o && waited < 400) begin
            if (id_o != prev_id) moved++;
            if (busy_start && waited == 3) start_i = 1'b1;
            else start_i = 1'b0;
            @(negedge clk);
            waited++;
        end
        start_i = 1'b0;
        chk(done_o == 1'b1, {tag, " R8 done seen"}, {63'h0, done_o}, 64'h1);
        chk(moved == 0, {tag, " R9 id held before done"}, 64'(moved), 64'h0);
        chk(ok_o == exp_ok && fail_o == !exp_ok, {tag, " R8 ok/fail"}, {62'h0, ok_o, fail_o}, {62'h0, exp_ok, !exp_ok});
        chk(id_o == want, exp_ok ? {tag, " R4 R6 id"} : {tag, " R7 id cleared"}, id_o, want);
        @(negedge clk);
        chk(!done_o && !ok_o && !fail_o, {tag, " R8 one-cycle done"}, {61'h0, done_o, ok_o, fail_o}, 64'h0);
        chk(id_o == want, {tag, " R9 id holds"}, id_o, want);
        repeat (15) begin
            @(negedge clk);
            if (done_o) extra_done++;
        end
        chk(extra_done == 0 && n_resets == 1, {tag, " R10 single attempt"}, 64'(n_resets + extra_done), 64'h1);
        chk(seq_err == 0 && n_ops == (present ? 10 : 1), {tag, " R1 R2 op sequence"}, 64'(n_ops), present ? 64'd10 : 64'd1);
    endtask

    task automatic make_rom(input logic [7:0] fam);
        rom[0] = fam;
        for (int i = 1; i < 7; i++) rom[i] = 8'($urandom);
        rom[7] = rom_crc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        dev_present = 1'b1;
        n_ops = 0; n_resets = 0; seq_err = 0;
        for (int i = 0; i < 8; i++) rom[i] = 8'h00;
        repeat (4) @(negedge clk);
        chk(!ow_req_o && !done_o && !ok_o && !fail_o && id_o == 64'h0, "R11 reset state",
            {60'h0, ow_req_o, done_o, ok_o, fail_o}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!ow_req_o, "R11 idle no request", {63'h0, ow_req_o}, 64'h0);

        // directed: known serial with correct CRC
        rom[0] = 8'h01; rom[1] = 8'h11; rom[2] = 8'h22; rom[3] = 8'h33;
        rom[4] = 8'h44; rom[5] = 8'h55; rom[6] = 8'h66; rom[7] = rom_crc();
        run(1'b1, 1'b1, 1'b0, "directed good");
        // R3 wrong family with consistent CRC
        make_rom(8'h02);
        run(1'b1, 1'b0, 1'b0, "R3 bad family");
        // R5 corrupted check byte
        make_rom(8'h01);
        rom[7] = rom[7] ^ 8'h01;
        run(1'b1, 1'b0, 1'b0, "R5 bad crc");
        // R2 absent device
        make_rom(8'h01);
        run(1'b0, 1'b0, 1'b0, "R2 absent");
        // R10 start while busy
        make_rom(8'h01);
        run(1'b1, 1'b1, 1'b1, "R10 busy start");
        // random mix
        for (int t = 0; t < 24; t++) begin
            int kind;
            kind = $urandom % 4;
            if (kind == 1) begin
                make_rom(8'($urandom % 255 + 2));
                run(1'b1, 1'b0, 1'b0, "rand R3 family");
            end else if (kind == 2) begin
                make_rom(8'h01);
                rom[7] = rom[7] ^ 8'($urandom % 255 + 1);
                run(1'b1, 1'b0, 1'b0, "rand R5 crc");
            end else begin
                make_rom(8'h01);
                run(1'b1, 1'b1, ($urandom % 2) == 1, "rand R6 good");
            end
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule